// File: doc/BRIEF.md
# Power Management Event Controller

This block gathers the power-management events of a system and turns them into a level interrupt for the operating system. A free-running timer advances on a tick-enable strobe, nominally at 3.579545 MHz. A change of the timer's top bit records a status event. A power-button input records a second status event. Software reaches the status, enable, control and timer registers over a simple register bus, with 16-bit writes and up to 32-bit combinational reads. Status bits clear when written with 1. The system control interrupt follows the enabled status bits.

Writing the control register with its sleep-go bit set starts a sleep action, chosen by a 3-bit sleep type. Type 0 requests a shutdown. Type 1 records a wake event and requests a system reset, with a suspend-to-RAM indication. A separate two-byte power-management port takes command bytes from firmware. Two command codes switch interrupt mode on and off. Every command write can raise a one-cycle SMI when the configuration input allows it.

Top module: `pm_evt_ctrl`

## Requirements
- R1: After reset, status, enable, control, timer, both APM bytes and every output read or sit at 0.
- R2: The timer is TMR_W bits wide and gains 1 on each clock with tick_i high, wrapping to 0. A read at offset 0x08 returns it zero-extended to 32 bits.
- R3: Status bit 0 sets on the clock where timer bit TMR_W-1 changes, in either direction.
- R4: A write to offset 0x00 clears each status bit written as 1 and leaves the bits written as 0 unchanged.
- R5: Offset 0x02 is a 16-bit read/write enable register. sci_o is high exactly when status AND enable has any of bits 10, 8, 5 or 0 set.
- R6: Offset 0x04 stores the control word except bit 13, which always reads 0. A write with bit 13 set and type bits 12:10 equal to 0 gives a one-cycle shutdown_req_o pulse on the next clock.
- R7: A write with bit 13 set and type 1 sets status bits 15 and 8 and gives a one-cycle reset_req_o pulse. It also raises sleep_s3_o, which stays high until reset.
- R8: With bit 13 clear, or with type 2 to 7, a control write issues no strobe and leaves status unchanged.
- R9: A clock with pwrbtn_i high sets status bit 8 only when enable bit 8 is set.
- R10: An APM write with apm_sel_i=0 stores the command byte. 0xF1 sets control bit 0, 0xF0 clears it, and other values leave it unchanged.
- R11: Each command write gives a one-cycle smi_o pulse on the next clock when smi_cfg_en_i is high, and no pulse when it is low.
- R12: With apm_sel_i=1 the APM port is a plain 8-bit read/write byte.
- R13: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer count enable |
| pwrbtn_i | input | 1 | Power-button event |
| smi_cfg_en_i | input | 1 | Allows SMI on command writes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| apm_we_i | input | 1 | APM port write strobe |
| apm_sel_i | input | 1 | 0 selects the command byte, 1 the status byte |
| apm_wdata_i | input | 8 | APM write data |
| apm_rdata_o | output | 8 | APM read data (combinational) |
| sci_o | output | 1 | Level system control interrupt |
| smi_o | output | 1 | One-cycle SMI pulse |
| shutdown_req_o | output | 1 | One-cycle shutdown request |
| reset_req_o | output | 1 | One-cycle reset request on suspend |
| sleep_s3_o | output | 1 | Suspend-to-RAM indication, held until reset |

## Verification
The bench builds the block with TMR_W=8, so the top timer bit changes after 128 ticks. The timer also wraps after 256 ticks. Both overflow directions, the wrap to zero and the status clear between them can therefore be reached in a few hundred cycles rather than millions. Every other behaviour is independent of the timer width and is exercised the same way as at the default of 24.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int unsigned REG_AW = 6;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned RD_W   = 32;
  localparam int unsigned APM_W  = 8;

  localparam logic [REG_AW-1:0] OFS_STS  = 6'h00;
  localparam logic [REG_AW-1:0] OFS_EN   = 6'h02;
  localparam logic [REG_AW-1:0] OFS_CTRL = 6'h04;
  localparam logic [REG_AW-1:0] OFS_TMR  = 6'h08;

  localparam int unsigned ST_TMR    = 0;
  localparam int unsigned ST_PWRBTN = 8;
  localparam int unsigned ST_WAKE   = 15;
  localparam int unsigned CT_SCI    = 0;
  localparam int unsigned CT_GO     = 13;
  localparam int unsigned CT_TYP_LO = 10;

  localparam logic [REG_W-1:0] SCI_SRC_MASK = 16'h0521;  // bits 10,8,5,0

  localparam logic [2:0] SLP_TYP_OFF = 3'd0;
  localparam logic [2:0] SLP_TYP_S3  = 3'd1;

  localparam logic [APM_W-1:0] APM_SCI_ON  = 8'hF1;
  localparam logic [APM_W-1:0] APM_SCI_OFF = 8'hF0;
endpackage

// File: rtl/pm_tmr.sv
module pm_tmr #(
  parameter int unsigned TMR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [TMR_W-1:0] count_o,
  output logic             ovf_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // top bit flips whenever all lower bits are ones and a tick arrives
  assign ovf_o   = tick_i & (&cnt_q[TMR_W-2:0]);
  assign count_o = cnt_q;
endmodule

// File: rtl/pm_apm.sv
module pm_apm
  import pm_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [APM_W-1:0] wdata_i,
  input  logic             smi_cfg_en_i,
  output logic [APM_W-1:0] rdata_o,
  output logic             sci_on_o,
  output logic             sci_off_o,
  output logic             smi_o
);
  logic [APM_W-1:0] cmd_q, sts_q;
  logic             smi_q;
  logic             cmd_wr;

  assign cmd_wr = we_i & ~sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      sts_q <= '0;
      smi_q <= 1'b0;
    end else begin
      if (cmd_wr)         cmd_q <= wdata_i;
      if (we_i && sel_i)  sts_q <= wdata_i;
      smi_q <= cmd_wr & smi_cfg_en_i;
    end
  end

  assign sci_on_o  = cmd_wr & (wdata_i == APM_SCI_ON);
  assign sci_off_o = cmd_wr & (wdata_i == APM_SCI_OFF);
  assign rdata_o   = sel_i ? sts_q : cmd_q;
  assign smi_o     = smi_q;
endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pm_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              ovf_i,
  input  logic              pwrbtn_i,
  input  logic              sci_on_i,
  input  logic              sci_off_i,
  output logic [REG_W-1:0]  status_o,
  output logic [REG_W-1:0]  enable_o,
  output logic [REG_W-1:0]  control_o,
  output logic              shutdown_req_o,
  output logic              reset_req_o,
  output logic              sleep_s3_o
);
  logic [REG_W-1:0] sts_q, en_q, ctl_q;
  logic [REG_W-1:0] sts_set, sts_clr, ctl_d;
  logic             sts_wr, en_wr, ctl_wr, go;
  logic [2:0]       slp_typ;
  logic             do_off, do_s3;
  logic             off_q, rst_req_q, s3_q;

  assign sts_wr  = we_i && (addr_i == OFS_STS);
  assign en_wr   = we_i && (addr_i == OFS_EN);
  assign ctl_wr  = we_i && (addr_i == OFS_CTRL);
  assign go      = ctl_wr & wdata_i[CT_GO];
  assign slp_typ = wdata_i[CT_TYP_LO +: 3];

  always_comb begin
    do_off = 1'b0;
    do_s3  = 1'b0;
    if (go) begin
      case (slp_typ)
        SLP_TYP_OFF: do_off = 1'b1;
        SLP_TYP_S3:  do_s3  = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    sts_set = '0;
    sts_set[ST_TMR]    = ovf_i;
    sts_set[ST_PWRBTN] = (pwrbtn_i & en_q[ST_PWRBTN]) | do_s3;
    sts_set[ST_WAKE]   = do_s3;
    sts_clr = sts_wr ? wdata_i : '0;
  end

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d = wdata_i;
      ctl_d[CT_GO] = 1'b0;
    end
    if (sci_on_i)  ctl_d[CT_SCI] = 1'b1;
    if (sci_off_i) ctl_d[CT_SCI] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q     <= '0;
      en_q      <= '0;
      ctl_q     <= '0;
      off_q     <= 1'b0;
      rst_req_q <= 1'b0;
      s3_q      <= 1'b0;
    end else begin
      sts_q     <= (sts_q & ~sts_clr) | sts_set;  // set wins over clear
      if (en_wr) en_q <= wdata_i;
      ctl_q     <= ctl_d;
      off_q     <= do_off;
      rst_req_q <= do_s3;
      if (do_s3) s3_q <= 1'b1;
    end
  end

  assign status_o       = sts_q;
  assign enable_o       = en_q;
  assign control_o      = ctl_q;
  assign shutdown_req_o = off_q;
  assign reset_req_o    = rst_req_q;
  assign sleep_s3_o     = s3_q;
endmodule

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
#(
  parameter int unsigned TMR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pwrbtn_i,
  input  logic              smi_cfg_en_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [RD_W-1:0]   reg_rdata_o,
  input  logic              apm_we_i,
  input  logic              apm_sel_i,
  input  logic [APM_W-1:0]  apm_wdata_i,
  output logic [APM_W-1:0]  apm_rdata_o,
  output logic              sci_o,
  output logic              smi_o,
  output logic              shutdown_req_o,
  output logic              reset_req_o,
  output logic              sleep_s3_o
);
  localparam int unsigned PAD_W = RD_W - TMR_W;

  logic [TMR_W-1:0] count_w;
  logic [REG_W-1:0] status_w, enable_w, control_w;
  logic             ovf_w, sci_on_w, sci_off_w;

  pm_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .count_o (count_w),
    .ovf_o   (ovf_w)
  );

  pm_apm u_apm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (apm_we_i),
    .sel_i        (apm_sel_i),
    .wdata_i      (apm_wdata_i),
    .smi_cfg_en_i (smi_cfg_en_i),
    .rdata_o      (apm_rdata_o),
    .sci_on_o     (sci_on_w),
    .sci_off_o    (sci_off_w),
    .smi_o        (smi_o)
  );

  pm_regs u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .we_i           (reg_we_i),
    .addr_i         (reg_addr_i),
    .wdata_i        (reg_wdata_i),
    .ovf_i          (ovf_w),
    .pwrbtn_i       (pwrbtn_i),
    .sci_on_i       (sci_on_w),
    .sci_off_i      (sci_off_w),
    .status_o       (status_w),
    .enable_o       (enable_w),
    .control_o      (control_w),
    .shutdown_req_o (shutdown_req_o),
    .reset_req_o    (reset_req_o),
    .sleep_s3_o     (sleep_s3_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      OFS_STS:  reg_rdata_o = {16'h0, status_w};
      OFS_EN:   reg_rdata_o = {16'h0, enable_w};
      OFS_CTRL: reg_rdata_o = {16'h0, control_w};
      OFS_TMR:  reg_rdata_o = {{PAD_W{1'b0}}, count_w};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign sci_o = |(status_w & enable_w & SCI_SRC_MASK);
endmodule

// File: rtl/pm_evt_ctrl_chk.sv
module pm_evt_ctrl_chk
  import pm_evt_pkg::*;
#(
  parameter int unsigned TMR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              pwrbtn_i,
  input logic              smi_cfg_en_i,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic              apm_we_i,
  input logic              apm_sel_i,
  input logic [TMR_W-1:0]  count_w,
  input logic [REG_W-1:0]  status_w,
  input logic [REG_W-1:0]  enable_w,
  input logic              sci_o,
  input logic              smi_o,
  input logic              shutdown_req_o
);
  a_r2_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> count_w == $past(count_w) + 1'b1);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_w));

  a_r3_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (&count_w[TMR_W-2:0])) |=> status_w[ST_TMR]);

  a_r9_pwrbtn_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrbtn_i && enable_w[ST_PWRBTN]) |=> status_w[ST_PWRBTN]);

  a_r5_sci_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_o |-> ((status_w & enable_w) != '0));

  a_r6_shutdown_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_req_o |-> $past(reg_we_i && reg_addr_i == OFS_CTRL &&
                             reg_wdata_i[CT_GO] && reg_wdata_i[CT_TYP_LO +: 3] == SLP_TYP_OFF));

  a_r11_smi_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> $past(apm_we_i && !apm_sel_i && smi_cfg_en_i));

  a_r11_smi_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smi_cfg_en_i |=> !smi_o);
endmodule

bind pm_evt_ctrl pm_evt_ctrl_chk #(.TMR_W(TMR_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tick_i         (tick_i),
  .pwrbtn_i       (pwrbtn_i),
  .smi_cfg_en_i   (smi_cfg_en_i),
  .reg_we_i       (reg_we_i),
  .reg_addr_i     (reg_addr_i),
  .reg_wdata_i    (reg_wdata_i),
  .apm_we_i       (apm_we_i),
  .apm_sel_i      (apm_sel_i),
  .count_w        (count_w),
  .status_w       (status_w),
  .enable_w       (enable_w),
  .sci_o          (sci_o),
  .smi_o          (smi_o),
  .shutdown_req_o (shutdown_req_o)
);

// File: tb/test_pm_evt_ctrl.sv
`timescale 1ns/1ps
module test_pm_evt_ctrl;
  localparam int unsigned TMR_W = 8;
  localparam int unsigned NV = 29;
  // op: 0 reg write, 1 reg read check, 2 apm write, 3 apm read check (addr[0] = sel)
  localparam logic [43:0] VEC [NV] = '{
    {2'd1, 4'd1,  6'h02, 32'h0000_0000},  // R1 enable reset
    {2'd1, 4'd1,  6'h04, 32'h0000_0000},  // R1 control reset
    {2'd1, 4'd1,  6'h00, 32'h0000_0000},  // R1 status reset
    {2'd0, 4'd5,  6'h02, 32'h0000_FFFF},  // R5
    {2'd1, 4'd5,  6'h02, 32'h0000_FFFF},
    {2'd0, 4'd5,  6'h02, 32'h0000_0000},
    {2'd0, 4'd6,  6'h04, 32'h0000_0006},  // R6 plain store
    {2'd1, 4'd6,  6'h04, 32'h0000_0006},
    {2'd0, 4'd6,  6'h04, 32'h0000_1C06},
    {2'd1, 4'd6,  6'h04, 32'h0000_1C06},
    {2'd0, 4'd8,  6'h04, 32'h0000_2800},  // R8 type 2 go
    {2'd1, 4'd8,  6'h04, 32'h0000_0800},
    {2'd1, 4'd8,  6'h00, 32'h0000_0000},
    {2'd0, 4'd13, 6'h0C, 32'h0000_1234},  // R13 unmapped
    {2'd1, 4'd13, 6'h0C, 32'h0000_0000},
    {2'd0, 4'd13, 6'h06, 32'h0000_FFFF},
    {2'd1, 4'd13, 6'h04, 32'h0000_0800},
    {2'd1, 4'd13, 6'h02, 32'h0000_0000},
    {2'd1, 4'd2,  6'h08, 32'h0000_0000},  // R2 idle timer
    {2'd2, 4'd12, 6'h01, 32'h0000_005A},  // R12 status byte
    {2'd3, 4'd12, 6'h01, 32'h0000_005A},
    {2'd3, 4'd10, 6'h00, 32'h0000_0000},  // R10 command byte
    {2'd2, 4'd10, 6'h00, 32'h0000_00F1},
    {2'd1, 4'd10, 6'h04, 32'h0000_0801},
    {2'd3, 4'd10, 6'h00, 32'h0000_00F1},
    {2'd2, 4'd10, 6'h00, 32'h0000_0033},
    {2'd1, 4'd10, 6'h04, 32'h0000_0801},
    {2'd2, 4'd10, 6'h00, 32'h0000_00F0},
    {2'd1, 4'd10, 6'h04, 32'h0000_0800}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, pwrbtn = 1'b0, smi_cfg = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        apm_we = 1'b0, apm_sel = 1'b0;
  logic [7:0]  apm_wdata = '0;
  logic [7:0]  apm_rdata;
  logic        sci, smi, shut, rreq, s3;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pm_evt_ctrl #(.TMR_W(TMR_W)) i_pm_evt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pwrbtn_i(pwrbtn),
    .smi_cfg_en_i(smi_cfg), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .apm_we_i(apm_we),
    .apm_sel_i(apm_sel), .apm_wdata_i(apm_wdata), .apm_rdata_o(apm_rdata),
    .sci_o(sci), .smi_o(smi), .shutdown_req_o(shut), .reset_req_o(rreq),
    .sleep_s3_o(s3)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic apm_wr(input logic s, input logic [7:0] d);
    @(negedge clk); apm_we = 1'b1; apm_sel = s; apm_wdata = d;
    @(negedge clk); apm_we = 1'b0;
  endtask

  task automatic apm_chk(input string tag, input logic s, input logic [7:0] exp);
    apm_sel = s; #1;
    chk(tag, {24'h0, apm_rdata}, {24'h0, exp});
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic press;
    @(negedge clk); pwrbtn = 1'b1;
    @(negedge clk); pwrbtn = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs at reset
    chk("R1 outputs", {27'h0, sci, smi, shut, rreq, s3}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      automatic logic [1:0]  op  = VEC[i][43:42];
      automatic logic [3:0]  rq  = VEC[i][41:38];
      automatic logic [5:0]  ad  = VEC[i][37:32];
      automatic logic [31:0] dat = VEC[i][31:0];
      automatic string       tg  = $sformatf("R%0d vec%0d", rq, i);
      case (op)
        2'd0: reg_wr(ad, dat[15:0]);
        2'd1: reg_chk(tg, ad, dat);
        2'd2: apm_wr(ad[0], dat[7:0]);
        default: apm_chk(tg, ad[0], dat[7:0]);
      endcase
    end

    // R2 / R3 rising edge of top bit
    ticks(127);
    reg_chk("R2 count", 6'h08, 32'h7F);
    reg_chk("R3 no ovf yet", 6'h00, 32'h0);
    ticks(1);
    reg_chk("R3 ovf rise", 6'h00, 32'h1);
    chk("R5 sci masked", {31'h0, sci}, 32'h0);
    reg_wr(6'h02, 16'h0001);
    chk("R5 sci on", {31'h0, sci}, 32'h1);
    // R4 write-one-to-clear
    reg_wr(6'h00, 16'h0000);
    reg_chk("R4 zero write", 6'h00, 32'h1);
    reg_wr(6'h00, 16'hFFFE);
    reg_chk("R4 other ones", 6'h00, 32'h1);
    reg_wr(6'h00, 16'h0001);
    reg_chk("R4 clear", 6'h00, 32'h0);
    chk("R5 sci off", {31'h0, sci}, 32'h0);
    // R2 wrap, R3 falling edge of top bit
    ticks(128);
    reg_chk("R2 wrap", 6'h08, 32'h0);
    reg_chk("R3 ovf fall", 6'h00, 32'h1);
    reg_wr(6'h00, 16'h0001);

    // R9 power button gated by enable bit 8
    press();
    reg_chk("R9 gated", 6'h00, 32'h0);
    reg_wr(6'h02, 16'h0100);
    press();
    reg_chk("R9 set", 6'h00, 32'h0100);
    chk("R9 sci", {31'h0, sci}, 32'h1);
    reg_wr(6'h00, 16'h0100);

    // R6 shutdown
    reg_wr(6'h04, 16'h2000);
    chk("R6 shutdown pulse", {30'h0, shut, rreq}, 32'h2);
    @(negedge clk);
    chk("R6 shutdown one cycle", {31'h0, shut}, 32'h0);
    reg_chk("R6 go not stored", 6'h04, 32'h0);

    // R7 suspend
    reg_wr(6'h04, 16'h2400);
    chk("R7 reset pulse", {29'h0, shut, rreq, s3}, 32'h3);
    @(negedge clk);
    chk("R7 reset one cycle", {30'h0, rreq, s3}, 32'h1);
    reg_chk("R7 wake status", 6'h00, 32'h8100);
    reg_chk("R7 control", 6'h04, 32'h0400);
    reg_wr(6'h00, 16'hFFFF);

    // R8 other sleep type
    reg_wr(6'h04, 16'h3400);
    chk("R8 no strobe", {30'h0, shut, rreq}, 32'h0);
    reg_chk("R8 status", 6'h00, 32'h0);

    // R11 SMI
    smi_cfg = 1'b1;
    apm_wr(1'b0, 8'h12);
    chk("R11 smi pulse", {31'h0, smi}, 32'h1);
    @(negedge clk);
    chk("R11 smi one cycle", {31'h0, smi}, 32'h0);
    smi_cfg = 1'b0;
    apm_wr(1'b0, 8'h13);
    chk("R11 smi gated", {31'h0, smi}, 32'h0);

    // R1 reset again from a busy state
    ticks(5);
    reg_wr(6'h02, 16'hFFFF);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 outputs again", {27'h0, sci, smi, shut, rreq, s3}, 32'h0);
    reg_chk("R1 timer", 6'h08, 32'h0);
    reg_chk("R1 enable", 6'h02, 32'h0);
    reg_chk("R1 control", 6'h04, 32'h0);
    apm_chk("R1 apm cmd", 1'b0, 8'h00);
    apm_chk("R1 apm sts", 1'b1, 8'h00);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule